// File: doc/BRIEF.md
# Toggle-Pointer Host Read Prefetch Buffer

This block holds up to four 32-bit words fetched from a PCI-side data port and hands them to a 64-bit host data port. A 5-bit host command selects what is read:
- restart at the first word,
- step forward through the buffer,
- read the first two words as one 64-bit quantity.

Stepping uses two alternating codes, A and B. The read pointer moves only when the code changes from one to the other. When the same step code is repeated, the current word is driven again. A host can therefore make several narrow reads of one word with no extra signalling.

A single-word read places the selected word on both halves of the host bus. The datapath keeps a fill pointer and a valid count, and it reports:
- the even parity of each word arriving from PCI;
- a sticky flag when a read touches an entry that has not been filled.

Address generation and PCI transfer control belong to neighbouring logic.

Top module: `rdpf_top`

## Requirements
- R1: After reset (`rstN` low, active low), `hostOe` is 0, `hostData` is 0, `underrun` is 0 and `pciPar` is 0. The read pointer is at entry 0 and no read command counts as previous.
- R2: Code 00000b (no operation) and every code other than 00100b, 00101b, 00110b and 00111b drive `hostOe` low and `hostData` to zero. They do not change the pointer.
- R3: Code 00100b sets the read pointer to entry 0 and drives entry 0. `hostOe` is high in the same cycle.
- R4: Code 00101b (step A) advances the pointer and drives the new entry when the previous read command was 00100b or 00110b. Otherwise it drives the current entry without advancing.
- R5: Code 00110b (step B) advances the pointer and drives the new entry only when the previous read command was 00101b. Otherwise it drives the current entry without advancing.
- R6: Code 00111b drives entry 0 on `hostData[31:0]` and entry 1 on `hostData[63:32]`, and leaves the pointer unchanged. A step command that follows it does not advance.
- R7: The read pointer saturates at entry 3. An advancing step at entry 3 drives entry 3 again.
- R8: Every single-word read (00100b, 00101b, 00110b) drives the same word on `hostData[63:32]` and `hostData[31:0]`. Output is combinational from the command in the same cycle.
- R9: Each cycle with `fillValid` high stores `fillData` at the next entry, in order from entry 0. Once four entries are held, further beats leave the stored data unchanged.
- R10: `fillClr` sets the fill pointer and the valid count to zero. When `fillValid` is high in the same cycle, that beat is stored at entry 0 and the count becomes 1.
- R11: A read whose driven entry (or entries 0 and 1 for 00111b) is not below the valid count sets `underrun` one cycle later. The flag stays set until reset or a `fillClr` cycle, and `fillClr` wins over a read in the same cycle.
- R12: On every cycle with `fillValid` high, `pciPar` takes the XOR of all 32 bits of `fillData` at the next edge (even parity). Otherwise it holds.
- R13: Cycles with a non-read code do not change which read command counts as previous for the step rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| fillClr | input | 1 | Restart filling at entry 0 |
| fillValid | input | 1 | PCI-side word valid this cycle |
| fillData | input | 32 | PCI-side word |
| hostCmd | input | 5 | Host read command code |
| hostData | output | 64 | Host data, both halves |
| hostOe | output | 1 | Host data drive enable (low means tri-stated) |
| pciPar | output | 1 | Even parity of the last PCI word beat |
| underrun | output | 1 | Sticky flag: a read touched an unfilled entry |

## Verification
The fill port and the host read port act in the same cycle, and `fillClr` may coincide with a new beat. The bench drives `fillClr` and `fillValid` together after an earlier fill. It then reads entry 0 to confirm that the new word landed there. A step to entry 1 must then raise `underrun`, which shows the count became exactly 1. In another case the bench issues a read of an unfilled entry in a cycle that also clears the fill state, and checks that the flag stays low.

// File: rtl/rdpf_pkg.sv
package rdpf_pkg;

  parameter int unsigned BUF_DEPTH = 4;
  localparam int unsigned PTR_W = $clog2(BUF_DEPTH);
  localparam int unsigned CNT_W = PTR_W + 1;

  localparam logic [4:0] CMD_NOP   = 5'b00000;
  localparam logic [4:0] CMD_FIRST = 5'b00100;
  localparam logic [4:0] CMD_STEPA = 5'b00101;
  localparam logic [4:0] CMD_STEPB = 5'b00110;
  localparam logic [4:0] CMD_QWORD = 5'b00111;

  typedef enum logic [2:0] {
    L_NONE, L_FIRST, L_STEPA, L_STEPB, L_QWORD
  } lastRd_e;

  typedef struct packed {
    logic             oe;
    logic             qword;
    logic [PTR_W-1:0] sel;
  } rdStrobe_t;

endpackage

// File: rtl/rdpf_ctrl.sv
module rdpf_ctrl
  import rdpf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [4:0] hostCmd,
  output rdStrobe_t  strobe
);

  logic [PTR_W-1:0] rdPtr, nxtPtr, incPtr;
  lastRd_e          lastRd, nxtLast;

  assign incPtr = (rdPtr == PTR_W'(BUF_DEPTH - 1)) ? rdPtr : rdPtr + PTR_W'(1);

  always_comb begin
    nxtPtr       = rdPtr;
    nxtLast      = lastRd;
    strobe.oe    = 1'b0;
    strobe.qword = 1'b0;
    case (hostCmd)
      CMD_FIRST: begin
        nxtPtr    = '0;
        nxtLast   = L_FIRST;
        strobe.oe = 1'b1;
      end
      CMD_STEPA: begin
        if (lastRd == L_FIRST || lastRd == L_STEPB) nxtPtr = incPtr;
        nxtLast   = L_STEPA;
        strobe.oe = 1'b1;
      end
      CMD_STEPB: begin
        if (lastRd == L_STEPA) nxtPtr = incPtr;
        nxtLast   = L_STEPB;
        strobe.oe = 1'b1;
      end
      CMD_QWORD: begin
        nxtLast      = L_QWORD;
        strobe.oe    = 1'b1;
        strobe.qword = 1'b1;
      end
      default: ;
    endcase
    strobe.sel = nxtPtr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr  <= '0;
      lastRd <= L_NONE;
    end else begin
      rdPtr  <= nxtPtr;
      lastRd <= nxtLast;
    end
  end

endmodule

// File: rtl/rdpf_dpath.sv
module rdpf_dpath
  import rdpf_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                fillClr,
  input  logic                fillValid,
  input  logic [DATA_W-1:0]   fillData,
  input  rdStrobe_t           strobe,
  output logic [2*DATA_W-1:0] hostData,
  output logic                hostOe,
  output logic                pciPar,
  output logic                underrun
);

  logic [DATA_W-1:0] mem [BUF_DEPTH];
  logic [PTR_W-1:0]  wrPtr, wrIdx;
  logic [CNT_W-1:0]  count;
  logic              wrEn, miss;

  assign wrEn  = fillValid && (fillClr || count < CNT_W'(BUF_DEPTH));
  assign wrIdx = fillClr ? '0 : wrPtr;

  for (genvar i = 0; i < BUF_DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rstN && wrEn && wrIdx == PTR_W'(i)) mem[i] <= fillData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      count <= '0;
    end else begin
      wrPtr <= wrIdx + PTR_W'(wrEn);
      if (fillClr) count <= CNT_W'(wrEn);
      else         count <= count + CNT_W'(wrEn);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          pciPar <= 1'b0;
    else if (fillValid) pciPar <= ^fillData;
  end

  assign miss = strobe.qword ? (count < CNT_W'(2))
                             : (CNT_W'(strobe.sel) >= count);

  always_ff @(posedge clk) begin
    if (!rstN)                  underrun <= 1'b0;
    else if (fillClr)           underrun <= 1'b0;
    else if (strobe.oe && miss) underrun <= 1'b1;
  end

  always_comb begin
    if (!strobe.oe)        hostData = '0;
    else if (strobe.qword) hostData = {mem[1], mem[0]};
    else                   hostData = {mem[strobe.sel], mem[strobe.sel]};
  end

  assign hostOe = strobe.oe;

endmodule

// File: rtl/rdpf_top.sv
module rdpf_top
  import rdpf_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                fillClr,
  input  logic                fillValid,
  input  logic [DATA_W-1:0]   fillData,
  input  logic [4:0]          hostCmd,
  output logic [2*DATA_W-1:0] hostData,
  output logic                hostOe,
  output logic                pciPar,
  output logic                underrun
);

  rdStrobe_t strobe;

  rdpf_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .hostCmd (hostCmd),
    .strobe  (strobe)
  );

  rdpf_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .fillClr   (fillClr),
    .fillValid (fillValid),
    .fillData  (fillData),
    .strobe    (strobe),
    .hostData  (hostData),
    .hostOe    (hostOe),
    .pciPar    (pciPar),
    .underrun  (underrun)
  );

endmodule

// File: rtl/rdpf_chk.sv
module rdpf_chk
  import rdpf_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                fillClr,
  input logic                fillValid,
  input logic [DATA_W-1:0]   fillData,
  input logic [4:0]          hostCmd,
  input logic [2*DATA_W-1:0] hostData,
  input logic                hostOe,
  input logic                pciPar,
  input logic                underrun,
  input logic [PTR_W-1:0]    rdPtr
);

  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (hostCmd == CMD_NOP) |-> (!hostOe && hostData == '0)); // R2

  AST_FIRST_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (hostCmd == CMD_FIRST) |=> (rdPtr == '0)); // R3

  AST_STEPA_REPEAT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (hostCmd == CMD_STEPA && $past(hostCmd) == CMD_STEPA && $past(!fillValid))
      |-> $stable(hostData)); // R4

  AST_QWORD_PTR_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (hostCmd == CMD_QWORD) |=> (rdPtr == $past(rdPtr))); // R6

  AST_HALVES_EQUAL: assert property (@(posedge clk) disable iff (!rstN)
    (hostOe && hostCmd != CMD_QWORD)
      |-> (hostData[2*DATA_W-1:DATA_W] == hostData[DATA_W-1:0])); // R8

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (underrun && !fillClr) |=> underrun); // R11

  AST_PAR_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    fillValid |=> (pciPar == ^$past(fillData))); // R12

endmodule

bind rdpf_top rdpf_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .fillClr   (fillClr),
  .fillValid (fillValid),
  .fillData  (fillData),
  .hostCmd   (hostCmd),
  .hostData  (hostData),
  .hostOe    (hostOe),
  .pciPar    (pciPar),
  .underrun  (underrun),
  .rdPtr     (u_ctrl.rdPtr)
);

// File: tb/sim_rdpf_top.sv
module sim_rdpf_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        fillClr, fillValid;
  logic [31:0] fillData;
  logic [4:0]  hostCmd;
  logic [63:0] hostData;
  logic        hostOe, pciPar, underrun;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  rdpf_top u0 (
    .clk(clk), .rstN(rstN), .fillClr(fillClr), .fillValid(fillValid),
    .fillData(fillData), .hostCmd(hostCmd), .hostData(hostData),
    .hostOe(hostOe), .pciPar(pciPar), .underrun(underrun)
  );

  localparam logic [31:0] D0 = 32'h1357_00A0;
  localparam logic [31:0] D1 = 32'h2468_00B1;
  localparam logic [31:0] D2 = 32'h0F0F_00C2;
  localparam logic [31:0] D3 = 32'hDEAD_00D3;
  localparam int NVEC = 17;
  // {cmd, expected oe, expected hostData}
  localparam logic [69:0] VEC [NVEC] = '{
    {5'b00100, 1'b1, D0, D0},     // R3 R8
    {5'b00101, 1'b1, D1, D1},     // R4 advance after first
    {5'b00101, 1'b1, D1, D1},     // R4 repeat holds
    {5'b00110, 1'b1, D2, D2},     // R5 advance after A
    {5'b00110, 1'b1, D2, D2},     // R5 repeat holds
    {5'b00000, 1'b0, 64'h0},      // R2
    {5'b00101, 1'b1, D3, D3},     // R13 nop ignored, R4 after B
    {5'b00110, 1'b1, D3, D3},     // R7 saturate
    {5'b00101, 1'b1, D3, D3},     // R7 saturate
    {5'b00111, 1'b1, D1, D0},     // R6
    {5'b00101, 1'b1, D3, D3},     // R6 step after qword holds
    {5'b00100, 1'b1, D0, D0},     // R3
    {5'b00110, 1'b1, D0, D0},     // R5 B after first holds
    {5'b00101, 1'b1, D1, D1},     // R4 A after B advances
    {5'b11100, 1'b0, 64'h0},      // R2 other code
    {5'b00111, 1'b1, D1, D0},     // R6
    {5'b00110, 1'b1, D1, D1}      // R6 pointer kept at 1
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill1(input logic [31:0] d, input logic clr);
    @(negedge clk);
    fillValid = 1'b1; fillData = d; fillClr = clr;
    @(negedge clk);
    fillValid = 1'b0; fillClr = 1'b0;
  endtask

  // drive cmd at a falling edge, sample a quarter period later
  task automatic rd(input logic [4:0] c);
    @(negedge clk);
    hostCmd = c;
    #5;
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; fillClr = 1'b0; fillValid = 1'b0; fillData = '0; hostCmd = 5'b0;
    repeat (3) @(posedge clk);
    #5;
    check(!hostOe && hostData == 0 && !underrun && !pciPar, "R1 reset",
          {hostOe, underrun, pciPar}, 0);
    @(negedge clk); rstN = 1'b1;

    // R9 in-order fill, R12 parity per beat
    fill1(D0, 1'b0);
    check(pciPar == ^D0, "R12 parity", pciPar, ^D0);
    fill1(D1, 1'b0);
    check(pciPar == ^D1, "R12 parity", pciPar, ^D1);
    fill1(D2, 1'b0);
    fill1(D3, 1'b0);
    check(pciPar == ^D3, "R12 parity", pciPar, ^D3);
    fill1(32'h0000_0001, 1'b0); // R9 beat beyond capacity ignored
    check(pciPar == 1'b1, "R12 parity on ignored beat", pciPar, 1);

    for (int i = 0; i < NVEC; i++) begin
      rd(VEC[i][69:65]);
      check(hostOe == VEC[i][64] && hostData == VEC[i][63:0],
            $sformatf("R3-step vector %0d", i), hostData, VEC[i][63:0]);
    end
    rd(5'b0);
    check(!underrun, "R11 no underrun when full", underrun, 0);

    // R9: full buffer kept entry 0 and 3 after the extra beat
    rd(5'b00100);
    check(hostData == {D0, D0}, "R9 entry0 kept", hostData, {D0, D0});
    rd(5'b00101); rd(5'b00110); rd(5'b00101);
    check(hostData == {D3, D3}, "R9 entry3 kept", hostData, {D3, D3});
    rd(5'b0);

    // R10 clear with simultaneous beat
    fill1(32'hCAFE_0000, 1'b1);
    rd(5'b00100);
    check(hostData == {32'hCAFE_0000, 32'hCAFE_0000}, "R10 clr+beat at entry0",
          hostData, {32'hCAFE_0000, 32'hCAFE_0000});
    rd(5'b0);
    check(!underrun, "R11 entry0 filled", underrun, 0);
    rd(5'b00111); // needs 2 entries
    rd(5'b0);
    check(underrun, "R11 qword underrun R10 count one", underrun, 1);
    rd(5'b0); rd(5'b0);
    check(underrun, "R11 sticky", underrun, 1);
    fill1(32'h0, 1'b1); // clears, stores one word
    check(!underrun, "R11 cleared by fillClr", underrun, 0);
    rd(5'b00101); // last was qword: holds at entry 0
    rd(5'b00110); // after A: advance to entry 1, unfilled
    rd(5'b0);
    check(underrun, "R11 step past count", underrun, 1);

    // R11 clear wins over read in the same cycle
    @(negedge clk);
    fillClr = 1'b1; hostCmd = 5'b00111;
    @(negedge clk);
    fillClr = 1'b0; hostCmd = 5'b0;
    #5;
    check(!underrun, "R11 clear wins", underrun, 0);

    // R1 reset mid-run
    @(negedge clk); rstN = 1'b0; hostCmd = 5'b00101;
    @(negedge clk); rstN = 1'b1; hostCmd = 5'b0;
    #5;
    check(!underrun && !pciPar && !hostOe, "R1 re-reset", {underrun, pciPar}, 0);
    fill1(D2, 1'b0);
    fill1(D3, 1'b0);
    rd(5'b00110); // R1 no previous command: B holds at 0
    check(hostData == {D2, D2}, "R1 R5 pointer at zero", hostData, {D2, D2});
    rd(5'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule